// File: doc/BRIEF.md
# Multiply-Accumulate Result Conditioner

This block sits behind the multiplier array of a multiply-accumulate unit and conditions what flows into and out of its accumulators. It owns four accumulators, each kept in a 64-bit register with 48 significant bits. It also owns a 12-bit status word that holds the mode controls, the condition flags and a sticky overflow bit for each accumulator. One command per request aligns or range-checks a raw product, clamps an accumulator in signed, unsigned or fractional style, reads an accumulator out as a rounded and optionally clamped word, or folds an accumulator's state into the condition flags. Loading, copying and status writes complete the set.

A request is a strobe on `valid_i` with a command code, a destination index, a source index and two 32-bit operands. The block acts on the clock edge that samples the strobe and raises `done_o` for exactly one cycle after it, with `res_o` and `stat_o` already updated. The sequencer has two states. `ST_IDLE` waits for work. `ST_RESP` marks the response cycle. Every state moves to `ST_RESP` when `valid_i` is high and to `ST_IDLE` when it is low, so back-to-back requests are accepted on every cycle.

Status word layout: bits 3:0 are the sticky overflow bits for accumulators 3..0. Bit 4 is EV (extension in use), bit 5 is V (overflow), bit 6 is Z and bit 7 is N. Bit 8 is RND (rounding on), bit 9 is SAT (saturate on overflow), bit 10 is SGN and bit 11 is FRAC. When FRAC=1, SGN selects 16-bit readout. When FRAC=0, SGN selects signed versus unsigned integer mode. Command codes: 0 LOAD, 1 SETST, 2 MULF, 3 MULS, 4 MULU, 5 SATS, 6 SATU, 7 SATF, 8 READ, 9 FLAGS, 10 MOVE. Codes 11 to 15 do nothing.

Top module: `macpost_top`

## Requirements
- R1: `done_o` is 1 in exactly the cycle after each cycle with `valid_i`=1, and 0 otherwise. An unused command code (11..15) sets `res_o` to 0 and leaves the accumulators and the status word unchanged. After reset, `res_o`, `stat_o` and `done_o` are 0.
- R2: LOAD (0) writes {opb_i, opa_i} into accumulator `idx_i` and returns it. MOVE (10) copies accumulator `src_i` into accumulator `idx_i`, copies sticky bit `src_i` onto sticky bit `idx_i`, and returns the copied value.
- R3: MULF (2) returns the unsigned product opa_i*opb_i shifted right by 24. With RND=1, 1 is added when the dropped 24 bits exceed 0x800000. When they equal 0x800000, the retained LSB is added.
- R4: MULS (3) forms the signed 64-bit product. If the product lies outside the signed 40-bit range, V is set, and with SAT=1 the result becomes +2^50 or -2^50 according to the product's sign. Otherwise the product is returned unchanged.
- R5: MULU (4) forms the unsigned product. If any of bits 63:40 are set, V is set and the result is 2^50 with SAT=1, or the product truncated to 40 bits with SAT=0.
- R6: SATS (5) sets V when accumulator `idx_i` differs from its 48-bit sign extension. The result is that sign extension. Whenever V is then 1, the accumulator's sticky bit is set, and with SAT=1 the value becomes 0x7FFFFFFF, or 0xFFFFFFFF80000000 if bit 63 was set. The result is written back and returned.
- R7: SATU (6) sets V when any of bits 63:48 are set. Whenever V is then 1, the sticky bit is set and the value becomes 0 if it exceeds 2^53 and 2^48-1 otherwise (SAT=1), or is masked to 48 bits (SAT=0). With V=0 the value is kept. The result is written back and returned.
- R8: SATF (7) behaves like SATS, except that with SAT=1 the clamp values are 0x00007FFFFFFFFFFF and its bitwise inverse.
- R9: READ (8) with FRAC=1 and SGN=1 arithmetic-shifts the accumulator right by 24, always rounds half-to-even on the dropped 24 bits, and returns 16 bits. With FRAC=1 and SGN=0, it shifts right by 8 and rounds half-to-even (half point 0x80) only when RND=1, then returns 32 bits. With SAT=1, a value outside the signed 16-bit or 32-bit range is clamped to that range's limit. Results are zero-extended into `res_o`.
- R10: READ with FRAC=0 returns a 32-bit word. In signed mode (SGN=1), a value outside the signed 32-bit range becomes 0x7FFFFFFF, or 0x80000000 if bit 63 is set. In unsigned mode (SGN=0), a value with any of bits 63:32 set becomes 0xFFFFFFFF.
- R11: FLAGS (9) sets Z if the accumulator is zero, and otherwise sets N if bit 47 is set. It sets V if the accumulator's sticky bit is set. It sets EV if bits 63:40 (FRAC=1) or bits 63:32 (FRAC=0, SGN=1) are not all equal, or if bits 63:32 are nonzero (FRAC=0, SGN=0). It returns the accumulator.
- R12: SETST (1) loads the status word from opa_i[11:0]. If FRAC or SGN changes, every accumulator is repacked. The old 32-bit core and low extension byte are taken from bits 39:8 and 7:0 in fractional layout, or from 31:0 and 39:32 in integer layout, and are placed in the new layout. Bits 47:40 are kept, and bits 63:48 are sign-filled from bit 47 unless the new mode is unsigned integer, in which case they are zero-filled.
- R13: Flag and sticky bits are only ever set by operations. They are cleared only by SETST, and by MOVE for the destination's sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| cmd_i | input | 4 | Command code |
| idx_i | input | 2 | Destination or target accumulator |
| src_i | input | 2 | Source accumulator for MOVE |
| opa_i | input | 32 | First operand, low load half, status value |
| opb_i | input | 32 | Second operand, high load half |
| done_o | output | 1 | One-cycle response pulse |
| res_o | output | 64 | Result of the last request |
| stat_o | output | 12 | Status word: modes, flags, sticky bits |

## Verification
A wrong accumulator value stays hidden until a later request reads it. The bench therefore reads accumulators back with self-MOVE and FLAGS requests, so a corrupted entry shows on `res_o` within two requests. A wrong flag or mode bit is exposed on `stat_o` in the very response cycle, because the status word is compared after every request. Rounding and repacking faults show only for particular bit patterns, so tie values, odd and even retained LSBs, and range-boundary values are applied as directed cases alongside the seeded random traffic.

// File: rtl/macpost_pkg.sv
package macpost_pkg;
    localparam int OP_W       = 32;
    localparam int WORD_W     = 2 * OP_W;
    localparam int ACC_W      = 48;
    localparam int PROD_W     = 40;
    localparam int ALIGN_SH   = 24;
    localparam int READ_SH    = 8;
    localparam int RD16_W     = 16;
    localparam int SAT_POW    = 50;
    localparam int UCLAMP_POW = 53;
    localparam int NUM_ACC    = 4;
    localparam int IDX_W      = $clog2(NUM_ACC);
    localparam int FLG_W      = 4;
    localparam int MODE_W     = 4;
    localparam int STAT_W     = NUM_ACC + FLG_W + MODE_W;

    // flag bit positions inside the flag field
    localparam int F_EV = 0;
    localparam int F_V  = 1;
    localparam int F_Z  = 2;
    localparam int F_N  = 3;
    // mode bit positions inside the mode field
    localparam int M_RND  = 0;
    localparam int M_SAT  = 1;
    localparam int M_SGN  = 2;
    localparam int M_FRAC = 3;

    localparam logic [WORD_W-1:0] BIG_PROD = WORD_W'(1) << SAT_POW;
    localparam logic [WORD_W-1:0] U_LIMIT  = WORD_W'(1) << UCLAMP_POW;
    localparam logic [WORD_W-1:0] MASK_ACC = (WORD_W'(1) << ACC_W) - WORD_W'(1);
    localparam logic [WORD_W-1:0] MASK_PRD = (WORD_W'(1) << PROD_W) - WORD_W'(1);
    localparam logic [WORD_W-1:0] POS_W32  = (WORD_W'(1) << (OP_W - 1)) - WORD_W'(1);
    localparam logic [WORD_W-1:0] POS_ACC  = (WORD_W'(1) << (ACC_W - 1)) - WORD_W'(1);
    localparam logic [ALIGN_SH-1:0] HALF_ALN = ALIGN_SH'(1) << (ALIGN_SH - 1);
    localparam logic [ALIGN_SH-1:0] HALF_RD  = ALIGN_SH'(1) << (READ_SH - 1);

    typedef enum logic [3:0] {
        CMD_LOAD  = 4'd0,
        CMD_SETST = 4'd1,
        CMD_MULF  = 4'd2,
        CMD_MULS  = 4'd3,
        CMD_MULU  = 4'd4,
        CMD_SATS  = 4'd5,
        CMD_SATU  = 4'd6,
        CMD_SATF  = 4'd7,
        CMD_READ  = 4'd8,
        CMD_FLAGS = 4'd9,
        CMD_MOVE  = 4'd10
    } cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

    // round half to even: bump when the dropped part is above half,
    // add the kept LSB when it is exactly half
    function automatic logic [WORD_W-1:0] round_even(
        input logic [WORD_W-1:0]   kept,
        input logic [ALIGN_SH-1:0] dropped,
        input logic [ALIGN_SH-1:0] half
    );
        logic [WORD_W-1:0] r;
        r = kept;
        if (dropped > half) begin
            r = kept + WORD_W'(1);
        end else if (dropped == half) begin
            r = kept + WORD_W'(kept[0]);
        end
        return r;
    endfunction
endpackage

// File: rtl/macpost_mul.sv
module macpost_mul
    import macpost_pkg::*;
(
    input  cmd_e              cmd_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic              rnd_i,
    input  logic              sat_i,
    output logic [WORD_W-1:0] res_o,
    output logic              ovf_o
);
    logic [WORD_W-1:0] uprod;
    logic [WORD_W-1:0] sprod;
    logic [WORD_W-1:0] aligned;
    logic              s_fits;
    logic              u_big;

    assign uprod = WORD_W'(a_i) * WORD_W'(b_i);
    assign sprod = {{(WORD_W-OP_W){a_i[OP_W-1]}}, a_i} *
                   {{(WORD_W-OP_W){b_i[OP_W-1]}}, b_i};
    assign s_fits = (&sprod[WORD_W-1:PROD_W-1]) | ~(|sprod[WORD_W-1:PROD_W-1]);
    assign u_big  = |uprod[WORD_W-1:PROD_W];

    always_comb begin
        aligned = uprod >> ALIGN_SH;
        if (rnd_i) begin
            aligned = round_even(uprod >> ALIGN_SH, uprod[ALIGN_SH-1:0], HALF_ALN);
        end
    end

    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        case (cmd_i)
            CMD_MULF: res_o = aligned;
            CMD_MULS: begin
                res_o = sprod;
                if (!s_fits) begin
                    ovf_o = 1'b1;
                    if (sat_i) begin
                        res_o = sprod[WORD_W-1] ? (~BIG_PROD + WORD_W'(1)) : BIG_PROD;
                    end
                end
            end
            CMD_MULU: begin
                res_o = uprod;
                if (u_big) begin
                    ovf_o = 1'b1;
                    res_o = sat_i ? BIG_PROD : (uprod & MASK_PRD);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/macpost_sat.sv
module macpost_sat
    import macpost_pkg::*;
(
    input  cmd_e              cmd_i,
    input  logic [WORD_W-1:0] val_i,
    input  logic              sat_i,
    input  logic              v_i,
    output logic [WORD_W-1:0] res_o,
    output logic              v_o,
    output logic              hit_o
);
    logic [WORD_W-1:0] sx;
    logic              sx_bad;
    logic              hi_set;

    assign sx     = {{(WORD_W-ACC_W){val_i[ACC_W-1]}}, val_i[ACC_W-1:0]};
    assign sx_bad = (sx != val_i);
    assign hi_set = |val_i[WORD_W-1:ACC_W];

    always_comb begin
        res_o = val_i;
        v_o   = v_i;
        hit_o = 1'b0;
        case (cmd_i)
            CMD_SATS: begin
                v_o   = v_i | sx_bad;
                hit_o = v_o;
                res_o = sx;
                if (v_o && sat_i) begin
                    res_o = val_i[WORD_W-1] ? ~POS_W32 : POS_W32;
                end
            end
            CMD_SATF: begin
                v_o   = v_i | sx_bad;
                hit_o = v_o;
                res_o = sx;
                if (v_o && sat_i) begin
                    res_o = val_i[WORD_W-1] ? ~POS_ACC : POS_ACC;
                end
            end
            CMD_SATU: begin
                v_o   = v_i | hi_set;
                hit_o = v_o;
                if (v_o) begin
                    if (sat_i) begin
                        res_o = (val_i > U_LIMIT) ? '0 : MASK_ACC;
                    end else begin
                        res_o = val_i & MASK_ACC;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/macpost_rdout.sv
module macpost_rdout
    import macpost_pkg::*;
(
    input  logic [WORD_W-1:0] val_i,
    input  logic              frac_i,
    input  logic              sgn_i,
    input  logic              rnd_i,
    input  logic              sat_i,
    output logic [WORD_W-1:0] rd_o,
    output logic              zf_o,
    output logic              nf_o,
    output logic              ev_o
);
    logic [WORD_W-1:0] q16;
    logic [WORD_W-1:0] q32;
    logic              fit16;
    logic              fit32;
    logic              ifit32;

    always_comb begin
        q16 = round_even($signed(val_i) >>> ALIGN_SH, val_i[ALIGN_SH-1:0], HALF_ALN);
        q32 = $signed(val_i) >>> READ_SH;
        if (rnd_i) begin
            q32 = round_even($signed(val_i) >>> READ_SH,
                             ALIGN_SH'(val_i[READ_SH-1:0]), HALF_RD);
        end
    end

    assign fit16  = (&q16[WORD_W-1:RD16_W-1]) | ~(|q16[WORD_W-1:RD16_W-1]);
    assign fit32  = (&q32[WORD_W-1:OP_W-1]) | ~(|q32[WORD_W-1:OP_W-1]);
    assign ifit32 = (&val_i[WORD_W-1:OP_W-1]) | ~(|val_i[WORD_W-1:OP_W-1]);

    always_comb begin
        rd_o = '0;
        if (frac_i) begin
            if (sgn_i) begin
                if (sat_i && !fit16) begin
                    rd_o = WORD_W'(q16[WORD_W-1] ? {1'b1, {(RD16_W-1){1'b0}}}
                                                 : {1'b0, {(RD16_W-1){1'b1}}});
                end else begin
                    rd_o = WORD_W'(q16[RD16_W-1:0]);
                end
            end else begin
                if (sat_i && !fit32) begin
                    rd_o = WORD_W'(q32[WORD_W-1] ? ~POS_W32 : POS_W32);
                    rd_o = rd_o & ((WORD_W'(1) << OP_W) - WORD_W'(1));
                end else begin
                    rd_o = WORD_W'(q32[OP_W-1:0]);
                end
            end
        end else if (sgn_i) begin
            if (!ifit32) begin
                rd_o = val_i[WORD_W-1] ? (POS_W32 + WORD_W'(1)) : POS_W32;
            end else begin
                rd_o = WORD_W'(val_i[OP_W-1:0]);
            end
        end else begin
            if (|val_i[WORD_W-1:OP_W]) begin
                rd_o = WORD_W'({OP_W{1'b1}});
            end else begin
                rd_o = WORD_W'(val_i[OP_W-1:0]);
            end
        end
    end

    always_comb begin
        zf_o = (val_i == '0);
        nf_o = !zf_o && val_i[ACC_W-1];
        if (frac_i) begin
            ev_o = !((&val_i[WORD_W-1:PROD_W]) | ~(|val_i[WORD_W-1:PROD_W]));
        end else if (sgn_i) begin
            ev_o = !((&val_i[WORD_W-1:OP_W]) | ~(|val_i[WORD_W-1:OP_W]));
        end else begin
            ev_o = |val_i[WORD_W-1:OP_W];
        end
    end
endmodule

// File: rtl/macpost_repack.sv
module macpost_repack
    import macpost_pkg::*;
(
    input  logic [ACC_W-1:0]  val_i,
    input  logic              old_frac_i,
    input  logic              new_frac_i,
    input  logic              new_sgn_i,
    output logic [WORD_W-1:0] val_o
);
    localparam int EXT_W  = ACC_W - PROD_W;
    localparam int FILL_W = WORD_W - ACC_W;

    logic [EXT_W-1:0] ext_hi;
    logic [OP_W-1:0]  core;
    logic [EXT_W-1:0] ext_lo;
    logic [FILL_W-1:0] fill;

    assign ext_hi = val_i[ACC_W-1:PROD_W];

    always_comb begin
        if (old_frac_i) begin
            core   = val_i[PROD_W-1:EXT_W];
            ext_lo = val_i[EXT_W-1:0];
        end else begin
            core   = val_i[OP_W-1:0];
            ext_lo = val_i[PROD_W-1:OP_W];
        end
        fill = (new_frac_i || new_sgn_i) ? {FILL_W{ext_hi[EXT_W-1]}} : '0;
        if (new_frac_i) begin
            val_o = {fill, ext_hi, core, ext_lo};
        end else begin
            val_o = {fill, ext_hi, ext_lo, core};
        end
    end
endmodule

// File: rtl/macpost_top.sv
module macpost_top
    import macpost_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        cmd_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [IDX_W-1:0]  src_i,
    input  logic [OP_W-1:0]   opa_i,
    input  logic [OP_W-1:0]   opb_i,
    output logic              done_o,
    output logic [WORD_W-1:0] res_o,
    output logic [STAT_W-1:0] stat_o
);
    fsm_e state_q, state_d;

    logic [WORD_W-1:0]  acc_q [NUM_ACC];
    logic [WORD_W-1:0]  acc_d [NUM_ACC];
    logic [WORD_W-1:0]  packed_v [NUM_ACC];
    logic [NUM_ACC-1:0] pv_q, pv_d;
    logic [FLG_W-1:0]   flg_q, flg_d;
    logic [MODE_W-1:0]  mode_q, mode_d;
    logic [WORD_W-1:0]  res_q, res_d;

    cmd_e              cmd_w;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] mul_res, sat_res, rd_res;
    logic              mul_ovf, sat_v, sat_hit;
    logic              zf, nf, evf;
    logic              new_frac, new_sgn, remap;

    assign cmd_w = cmd_e'(cmd_i);
    assign cur   = acc_q[idx_i];

    macpost_mul u_mul (
        .cmd_i (cmd_w),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .rnd_i (mode_q[M_RND]),
        .sat_i (mode_q[M_SAT]),
        .res_o (mul_res),
        .ovf_o (mul_ovf)
    );

    macpost_sat u_sat (
        .cmd_i (cmd_w),
        .val_i (cur),
        .sat_i (mode_q[M_SAT]),
        .v_i   (flg_q[F_V]),
        .res_o (sat_res),
        .v_o   (sat_v),
        .hit_o (sat_hit)
    );

    macpost_rdout u_rd (
        .val_i  (cur),
        .frac_i (mode_q[M_FRAC]),
        .sgn_i  (mode_q[M_SGN]),
        .rnd_i  (mode_q[M_RND]),
        .sat_i  (mode_q[M_SAT]),
        .rd_o   (rd_res),
        .zf_o   (zf),
        .nf_o   (nf),
        .ev_o   (evf)
    );

    assign new_frac = opa_i[NUM_ACC + FLG_W + M_FRAC];
    assign new_sgn  = opa_i[NUM_ACC + FLG_W + M_SGN];
    assign remap    = (new_frac != mode_q[M_FRAC]) || (new_sgn != mode_q[M_SGN]);

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_repack
        macpost_repack u_rp (
            .val_i      (acc_q[g][ACC_W-1:0]),
            .old_frac_i (mode_q[M_FRAC]),
            .new_frac_i (new_frac),
            .new_sgn_i  (new_sgn),
            .val_o      (packed_v[g])
        );
    end

    // state register transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = valid_i ? ST_RESP : ST_IDLE;
        endcase
    end

    // output decode of the state
    always_comb begin
        done_o = (state_q == ST_RESP);
    end

    // datapath next values
    always_comb begin
        acc_d  = acc_q;
        pv_d   = pv_q;
        flg_d  = flg_q;
        mode_d = mode_q;
        res_d  = '0;
        if (valid_i) begin
            case (cmd_w)
                CMD_LOAD: begin
                    acc_d[idx_i] = {opb_i, opa_i};
                    res_d        = {opb_i, opa_i};
                end
                CMD_SETST: begin
                    {mode_d, flg_d, pv_d} = opa_i[STAT_W-1:0];
                    if (remap) begin
                        acc_d = packed_v;
                    end
                end
                CMD_MULF: res_d = mul_res;
                CMD_MULS, CMD_MULU: begin
                    res_d      = mul_res;
                    flg_d[F_V] = flg_q[F_V] | mul_ovf;
                end
                CMD_SATS, CMD_SATU, CMD_SATF: begin
                    acc_d[idx_i] = sat_res;
                    res_d        = sat_res;
                    flg_d[F_V]   = sat_v;
                    if (sat_hit) begin
                        pv_d[idx_i] = 1'b1;
                    end
                end
                CMD_READ: res_d = rd_res;
                CMD_FLAGS: begin
                    res_d       = cur;
                    flg_d[F_Z]  = flg_q[F_Z] | zf;
                    flg_d[F_N]  = flg_q[F_N] | nf;
                    flg_d[F_V]  = flg_q[F_V] | pv_q[idx_i];
                    flg_d[F_EV] = flg_q[F_EV] | evf;
                end
                CMD_MOVE: begin
                    acc_d[idx_i] = acc_q[src_i];
                    pv_d[idx_i]  = pv_q[src_i];
                    res_d        = acc_q[src_i];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pv_q    <= '0;
            flg_q   <= '0;
            mode_q  <= '0;
            res_q   <= '0;
            for (int i = 0; i < NUM_ACC; i++) begin
                acc_q[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            pv_q    <= pv_d;
            flg_q   <= flg_d;
            mode_q  <= mode_d;
            res_q   <= res_d;
            for (int i = 0; i < NUM_ACC; i++) begin
                acc_q[i] <= acc_d[i];
            end
        end
    end

    assign res_o  = res_q;
    assign stat_o = {mode_q, flg_q, pv_q};

    // R1
    done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    // R1
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(valid_i));

    // R13
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(valid_i && (cmd_i == CMD_SETST || cmd_i == CMD_MOVE)))
        |=> ((pv_q & $past(pv_q)) == $past(pv_q)));

    // R7
    satu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cmd_i == CMD_SATU) |=> (res_o[WORD_W-1:ACC_W] == '0));

    // R6
    sats_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cmd_i == CMD_SATS)
        |=> ((&res_o[WORD_W-1:ACC_W-1]) || !(|res_o[WORD_W-1:ACC_W-1])));

    // R9
    read16_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cmd_i == CMD_READ && mode_q[M_FRAC] && mode_q[M_SGN])
        |=> (res_o[WORD_W-1:RD16_W] == '0));
endmodule

// File: tb/sim_macpost_top.sv
module sim_macpost_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [3:0]  cmd = '0;
    logic [1:0]  idx = '0;
    logic [1:0]  src = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        done;
    logic [63:0] res;
    logic [11:0] stat;

    int n_checks = 0;
    int n_errors = 0;

    // reference state
    logic [63:0] m_acc [4];
    logic [3:0]  m_pv;
    logic [3:0]  m_flg;   // [0]EV [1]V [2]Z [3]N
    logic [3:0]  m_mode;  // [0]RND [1]SAT [2]SGN [3]FRAC

    macpost_top u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid),
        .cmd_i   (cmd),
        .idx_i   (idx),
        .src_i   (src),
        .opa_i   (opa),
        .opb_i   (opb),
        .done_o  (done),
        .res_o   (res),
        .stat_o  (stat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int c);
        case (c)
            0, 10: return "R2";
            1: return "R12";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            7: return "R8";
            8: return (m_mode[3]) ? "R9" : "R10";
            9: return "R11";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [63:0] sx48(input logic [63:0] v);
        return {{16{v[47]}}, v[47:0]};
    endfunction

    function automatic longint rne(input longint q, input longint unsigned rem, input longint unsigned half);
        if (rem > half) return q + 1;
        if (rem == half) return q + longint'(q[0]);
        return q;
    endfunction

    function automatic bit in_range(input longint x, input int bits);
        longint lim;
        lim = longint'(1) << (bits - 1);
        return (x >= -lim) && (x < lim);
    endfunction

    task automatic model(input int c, input int ix, input int sx, input logic [31:0] a,
                         input logic [31:0] b, output logic [63:0] er);
        logic [63:0] v, p, r;
        longint      sp;
        bit          ov;
        v  = m_acc[ix];
        er = '0;
        case (c)
            0: begin m_acc[ix] = {b, a}; er = {b, a}; end
            1: begin
                if (a[11] != m_mode[3] || a[10] != m_mode[2]) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0]  eh, el;
                        logic [31:0] cr;
                        logic [15:0] fl;
                        eh = m_acc[k][47:40];
                        if (m_mode[3]) begin cr = m_acc[k][39:8]; el = m_acc[k][7:0]; end
                        else begin cr = m_acc[k][31:0]; el = m_acc[k][39:32]; end
                        fl = (a[11] || a[10]) ? {16{eh[7]}} : 16'h0;
                        m_acc[k] = a[11] ? {fl, eh, cr, el} : {fl, eh, el, cr};
                    end
                end
                {m_mode, m_flg, m_pv} = a[11:0];
            end
            2: begin
                p  = 64'(a) * 64'(b);
                er = p >> 24;
                if (m_mode[0]) er = 64'(rne(longint'(p >> 24), longint'(p[23:0]), 64'h800000));
            end
            3: begin
                sp = longint'($signed(a)) * longint'($signed(b));
                er = sp;
                if (!in_range(sp, 40)) begin
                    m_flg[1] = 1'b1;
                    if (m_mode[1]) er = (sp < 0) ? -(longint'(1) << 50) : (longint'(1) << 50);
                end
            end
            4: begin
                p  = 64'(a) * 64'(b);
                er = p;
                if (p >= (64'd1 << 40)) begin
                    m_flg[1] = 1'b1;
                    er = m_mode[1] ? (64'd1 << 50) : (p & ((64'd1 << 40) - 1));
                end
            end
            5, 7: begin
                ov = m_flg[1] || !in_range(longint'(v), 48);
                r  = sx48(v);
                if (ov) begin
                    m_pv[ix] = 1'b1;
                    if (m_mode[1]) begin
                        if (c == 5) r = v[63] ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
                        else        r = v[63] ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF;
                    end
                end
                m_flg[1] = ov; m_acc[ix] = r; er = r;
            end
            6: begin
                ov = m_flg[1] || (v >= (64'd1 << 48));
                r  = v;
                if (ov) begin
                    m_pv[ix] = 1'b1;
                    if (m_mode[1]) r = (v > (64'd1 << 53)) ? 64'd0 : ((64'd1 << 48) - 1);
                    else r = v & ((64'd1 << 48) - 1);
                end
                m_flg[1] = ov; m_acc[ix] = r; er = r;
            end
            8: begin
                if (m_mode[3] && m_mode[2]) begin
                    sp = rne($signed(v) >>> 24, longint'(v[23:0]), 64'h800000);
                    if (m_mode[1] && !in_range(sp, 16)) er = (sp < 0) ? 64'h8000 : 64'h7FFF;
                    else er = 64'(sp[15:0]);
                end else if (m_mode[3]) begin
                    sp = $signed(v) >>> 8;
                    if (m_mode[0]) sp = rne(sp, longint'(v[7:0]), 64'h80);
                    if (m_mode[1] && !in_range(sp, 32)) er = (sp < 0) ? 64'h8000_0000 : 64'h7FFF_FFFF;
                    else er = 64'(sp[31:0]);
                end else if (m_mode[2]) begin
                    if (!in_range(longint'(v), 32)) er = v[63] ? 64'h8000_0000 : 64'h7FFF_FFFF;
                    else er = 64'(v[31:0]);
                end else begin
                    er = (v[63:32] != 0) ? 64'hFFFF_FFFF : 64'(v[31:0]);
                end
            end
            9: begin
                if (v == 0) m_flg[2] = 1'b1;
                else if (v[47]) m_flg[3] = 1'b1;
                if (m_pv[ix]) m_flg[1] = 1'b1;
                if (m_mode[3]) begin
                    sp = $signed(v) >>> 40;
                    if (sp != 0 && sp != -1) m_flg[0] = 1'b1;
                end else if (m_mode[2]) begin
                    sp = $signed(v) >>> 32;
                    if (sp != 0 && sp != -1) m_flg[0] = 1'b1;
                end else if (v[63:32] != 0) begin
                    m_flg[0] = 1'b1;
                end
                er = v;
            end
            10: begin
                r = m_acc[sx];
                m_pv[ix] = m_pv[sx];
                m_acc[ix] = r;
                er = r;
            end
            default: ;
        endcase
    endtask

    task automatic run_op(input int c, input int ix, input int sx, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] er;
        string tg;
        @(negedge clk);
        tg = tag_of(c);
        valid = 1'b1; cmd = 4'(c); idx = 2'(ix); src = 2'(sx); opa = a; opb = b;
        model(c, ix, sx, a, b, er);
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        chk(tg, res, er);
        chk((c == 9 || c == 1) ? tg : "R13", 64'(stat), 64'({m_mode, m_flg, m_pv}));
        chk("R1", 64'(done), 64'd1);
    endtask

    task automatic load(input int ix, input logic [63:0] v);
        run_op(0, ix, 0, v[31:0], v[63:32]);
    endtask

    task automatic setst(input logic [11:0] s);
        run_op(1, 0, 0, 32'(s), 32'd0);
    endtask

    function automatic logic [31:0] pick_word();
        case ($urandom % 6)
            0: return $urandom;
            1: return 32'h7FFF_FFFF;
            2: return 32'h8000_0000;
            3: return $urandom % 256;
            4: return 32'h0080_0000 | ($urandom % 2);
            default: return 32'hFFFF_0000 | $urandom;
        endcase
    endfunction

    function automatic logic [63:0] pick_acc();
        logic [63:0] w;
        w = {$urandom, $urandom};
        case ($urandom % 6)
            0: return w;
            1: return sx48(w);
            2: return {32'd0, w[31:0]};
            3: return (64'd1 << 53) + 64'($urandom % 3) - 64'd1;
            4: return {{24{w[39]}}, w[39:0]};
            default: return {w[63:8], 8'h80};
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < 4; k++) m_acc[k] = '0;
        m_pv = '0; m_flg = '0; m_mode = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", res, 64'd0);
        chk("R1", 64'(stat), 64'd0);
        chk("R1", 64'(done), 64'd0);

        // R3 tie cases: even kept LSB stays, odd is bumped, above half rounds up
        setst(12'h100);
        run_op(2, 0, 0, 32'd1, 32'h0080_0000);
        chk("R3", res, 64'd0);
        run_op(2, 0, 0, 32'd3, 32'h0080_0000);
        chk("R3", res, 64'd2);
        run_op(2, 0, 0, 32'd1, 32'h0080_0001);
        chk("R3", res, 64'd1);
        setst(12'h000);
        run_op(2, 0, 0, 32'd3, 32'h0080_0000);
        chk("R3", res, 64'd1);

        // R4 / R5 overflow with saturation
        setst(12'h200);
        run_op(3, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        chk("R4", res, 64'd1 << 50);
        run_op(3, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF);
        chk("R4", res, -(64'd1 << 50));
        run_op(4, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R5", res, 64'd1 << 50);

        // R6 / R7 / R8 clamps
        setst(12'h600);
        load(1, 64'h0001_0000_0000_0000);
        run_op(5, 1, 0, 32'd0, 32'd0);
        chk("R6", res, 64'h7FFF_FFFF);
        chk("R6", 64'(stat[1]), 64'd1);
        setst(12'h200);
        load(2, 64'h0030_0000_0000_0001);
        run_op(6, 2, 0, 32'd0, 32'd0);
        chk("R7", res, 64'd0);
        load(2, 64'h0001_0000_0000_0000);
        run_op(7, 2, 0, 32'd0, 32'd0);
        chk("R8", res, 64'h0000_7FFF_FFFF_FFFF);

        // R9 16-bit fractional tie and clamp, R10 integer clamps
        setst(12'hE00);
        load(0, 64'h0000_0000_0380_0000);
        run_op(8, 0, 0, 32'd0, 32'd0);
        chk("R9", res, 64'h4);
        setst(12'h400);
        load(0, 64'hFFFF_FFF0_0000_0000);
        run_op(8, 0, 0, 32'd0, 32'd0);
        chk("R10", res, 64'h8000_0000);

        // R11 zero flag, R13 flag persists across a clean op
        setst(12'h000);
        load(3, 64'd0);
        run_op(9, 3, 0, 32'd0, 32'd0);
        chk("R11", 64'(stat[6]), 64'd1);
        run_op(5, 3, 0, 32'd0, 32'd0);
        chk("R13", 64'(stat[6]), 64'd1);

        // R12 repack from integer to fractional layout
        setst(12'h000);
        load(1, 64'h0000_AB12_3456_78CD);
        setst(12'h800);
        run_op(10, 1, 1, 32'd0, 32'd0);
        chk("R12", res, 64'hFFFF_AB34_5678_CD12);

        // R2 move copies sticky bit
        setst(12'h001);
        run_op(10, 2, 0, 32'd0, 32'd0);
        chk("R2", 64'(stat[2]), 64'd1);

        // R1 unused code and idle done
        run_op(15, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R1", res, 64'd0);
        @(negedge clk);
        chk("R1", 64'(done), 64'd0);

        // seeded random traffic
        for (int it = 0; it < 1500; it++) begin
            int c;
            logic [63:0] w;
            c = $urandom % 12;
            if (c == 11) c = 13;
            if (c == 0) begin
                w = pick_acc();
                load($urandom % 4, w);
            end else if (c == 1) begin
                setst(12'($urandom));
            end else begin
                run_op(c, $urandom % 4, $urandom % 4, pick_word(), pick_word());
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule